// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block sequences start-up and overcurrent recovery for a switching regulator's pulse-width control path. A digital soft-start level stands in for the ramp on a timing capacitor. It climbs slowly by a small charge step each clock, and falls quickly by a larger drain step. The error command sent on to the pulse-width comparator is limited to this level. Output pulses therefore widen gradually after power-up and after every fault.

An overcurrent indication latches a fault and removes the output enable in the same cycle. When the fault arrives while the converter is running normally, the level drains straight away. When it arrives during a soft start, the level first climbs to its full value and only then drains. This gives a persistent short a hiccup period with a fixed lower bound. The block re-arms only when the level has fallen below a low restart threshold and the overcurrent indication has cleared. Whenever the supply-good input is low, the block stays locked out with the level at zero.

Top module: `hiccup_seq`

## Requirements
- R1: After reset, and while `supply_ok` is low, `state_o` reads 0 (lockout), `out_en` is 0, `cmd_out` is 0 and `fault_st` is 0.
- R2: When `supply_ok` is low at a clock edge, in any state, the block enters lockout after that edge, clears the fault and sets the soft-start level to zero. A later soft start then begins from zero.
- R3: `state_o` encodes the states as lockout=0, soft start=1, run=2, fault charge=3 and fault drain=4. Lockout moves to soft start at the first edge with `supply_ok` high, with the level at zero. In soft start, run and fault charge, the level rises by `CHG_STEP` at each edge and saturates at `FULL_LVL`.
- R4: In soft start and in run, `cmd_out` equals the smaller of `err_cmd` and the soft-start level, and follows `err_cmd` combinationally. In every other state, `cmd_out` is 0.
- R5: Soft start moves to run at the first edge at which the level is at or above `FULL_LVL` and `oc_flag` is low.
- R6: While `oc_flag` is high, `out_en` is 0 in the same cycle, whatever the state.
- R7: An edge in run with `oc_flag` high enters fault drain. In fault drain, the level falls by `DIS_STEP` per edge and saturates at zero.
- R8: An edge in soft start with `oc_flag` high enters fault charge. The level keeps rising until it is at `FULL_LVL`, and the following edge enters fault drain.
- R9: Fault drain returns to soft start only at an edge where the level is below `RESTART_LVL` and `oc_flag` is low. Otherwise the block stays in fault drain.
- R10: `fault_st` is 1 exactly in the two fault states. In those states, and in lockout, `out_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Both supply monitors report good |
| oc_flag | input | 1 | Overcurrent comparator output |
| err_cmd | input | SS_W | Raw error-amplifier command |
| out_en | output | 1 | Output-driver enable |
| cmd_out | output | SS_W | Command clamped to the soft-start level |
| fault_st | output | 1 | Fault latch status |
| state_o | output | 3 | Current sequencer state code |

## Verification
The hardest case to reach is a fault that lands during a soft start. The bench has to raise `oc_flag` partway up the ramp and then release it. Only the timing of the later transitions shows that the level kept climbing to full before it drained: fault charge lasts a number of cycles set by the remaining distance to full, and only then does fault drain begin. The stimulus also holds `oc_flag` high after the level has drained to zero, to show that restart waits for the flag to clear. It drops `supply_ok` in the middle of a fault to show that the latch clears and the next ramp begins from zero.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    typedef enum logic [2:0] {
        ST_LOCKOUT   = 3'd0,
        ST_SOFTSTART = 3'd1,
        ST_RUN       = 3'd2,
        ST_FLT_CHG   = 3'd3,
        ST_FLT_DIS   = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        LVL_CLEAR  = 2'd0,
        LVL_CHARGE = 2'd1,
        LVL_DRAIN  = 2'd2
    } lvl_mode_e;

    // Pulses may be issued in these states
    function automatic logic is_active(seq_state_e s);
        return (s == ST_SOFTSTART) || (s == ST_RUN);
    endfunction

    // Fault latch is set in these states
    function automatic logic is_fault(seq_state_e s);
        return (s == ST_FLT_CHG) || (s == ST_FLT_DIS);
    endfunction

endpackage

// File: rtl/ss_level.sv
module ss_level
    import hiccup_pkg::*;
#(
    parameter int SS_W     = 10,
    parameter int CHG_STEP = 1,
    parameter int DIS_STEP = 25,
    parameter int FULL_LVL = 1000
) (
    input  logic            clk,
    input  logic            rst,
    input  lvl_mode_e       mode,
    output logic [SS_W-1:0] lvl
);
    localparam logic [SS_W:0]   UP_X   = (SS_W+1)'(CHG_STEP);
    localparam logic [SS_W:0]   TOP_X  = (SS_W+1)'(FULL_LVL);
    localparam logic [SS_W-1:0] DN_X   = SS_W'(DIS_STEP);

    logic [SS_W-1:0] lvl_q;
    logic [SS_W-1:0] lvl_d;
    logic [SS_W:0]   up_sum;

    always_comb begin
        up_sum = {1'b0, lvl_q} + UP_X;
        unique case (mode)
            LVL_CHARGE: lvl_d = (up_sum > TOP_X) ? TOP_X[SS_W-1:0] : up_sum[SS_W-1:0];
            LVL_DRAIN:  lvl_d = (lvl_q < DN_X) ? '0 : lvl_q - DN_X;
            default:    lvl_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl_d;
    end

    assign lvl = lvl_q;

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import hiccup_pkg::*;
#(
    parameter int SS_W        = 10,
    parameter int FULL_LVL    = 1000,
    parameter int RESTART_LVL = 100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            supply_ok,
    input  logic            oc_flag,
    input  logic [SS_W-1:0] lvl,
    output seq_state_e      state,
    output lvl_mode_e       mode
);
    localparam logic [SS_W-1:0] FULL_X = SS_W'(FULL_LVL);
    localparam logic [SS_W-1:0] RST_X  = SS_W'(RESTART_LVL);

    seq_state_e st_q;
    seq_state_e st_d;

    always_comb begin
        st_d = st_q;
        mode = LVL_CHARGE;
        if (!supply_ok) begin
            st_d = ST_LOCKOUT;
            mode = LVL_CLEAR;
        end else begin
            unique case (st_q)
                ST_LOCKOUT: begin
                    mode = LVL_CLEAR;
                    st_d = ST_SOFTSTART;
                end
                ST_SOFTSTART: begin
                    if (oc_flag)            st_d = ST_FLT_CHG;
                    else if (lvl >= FULL_X) st_d = ST_RUN;
                end
                ST_RUN: begin
                    if (oc_flag) st_d = ST_FLT_DIS;
                end
                ST_FLT_CHG: begin
                    if (lvl >= FULL_X) st_d = ST_FLT_DIS;
                end
                ST_FLT_DIS: begin
                    mode = LVL_DRAIN;
                    if ((lvl < RST_X) && !oc_flag) st_d = ST_SOFTSTART;
                end
                default: begin
                    mode = LVL_CLEAR;
                    st_d = ST_LOCKOUT;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_LOCKOUT;
        else     st_q <= st_d;
    end

    assign state = st_q;

endmodule

// File: rtl/cmd_clamp.sv
module cmd_clamp
    import hiccup_pkg::*;
#(
    parameter int SS_W = 10
) (
    input  seq_state_e      state,
    input  logic            oc_flag,
    input  logic [SS_W-1:0] lvl,
    input  logic [SS_W-1:0] err_cmd,
    output logic            out_en,
    output logic [SS_W-1:0] cmd_out
);
    logic active;

    always_comb begin
        active  = is_active(state);
        out_en  = active && !oc_flag;
        cmd_out = active ? ((err_cmd < lvl) ? err_cmd : lvl) : '0;
    end

endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
    import hiccup_pkg::*;
#(
    parameter int SS_W        = 10,
    parameter int CHG_STEP    = 1,
    parameter int DIS_STEP    = 25,
    parameter int FULL_LVL    = 1000,
    parameter int RESTART_LVL = 100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            supply_ok,
    input  logic            oc_flag,
    input  logic [SS_W-1:0] err_cmd,
    output logic            out_en,
    output logic [SS_W-1:0] cmd_out,
    output logic            fault_st,
    output logic [2:0]      state_o
);
    seq_state_e      state;
    lvl_mode_e       mode;
    logic [SS_W-1:0] ss_q;

    seq_fsm #(
        .SS_W(SS_W), .FULL_LVL(FULL_LVL), .RESTART_LVL(RESTART_LVL)
    ) u_fsm (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .oc_flag(oc_flag),
        .lvl(ss_q), .state(state), .mode(mode)
    );

    ss_level #(
        .SS_W(SS_W), .CHG_STEP(CHG_STEP), .DIS_STEP(DIS_STEP), .FULL_LVL(FULL_LVL)
    ) u_lvl (
        .clk(clk), .rst(rst), .mode(mode), .lvl(ss_q)
    );

    cmd_clamp #(.SS_W(SS_W)) u_clamp (
        .state(state), .oc_flag(oc_flag), .lvl(ss_q), .err_cmd(err_cmd),
        .out_en(out_en), .cmd_out(cmd_out)
    );

    assign fault_st = is_fault(state);
    assign state_o  = state;

endmodule

// File: rtl/hiccup_seq_chk.sv
module hiccup_seq_chk #(
    parameter int SS_W = 10
) (
    input logic            clk,
    input logic            rst,
    input logic            supply_ok,
    input logic            oc_flag,
    input logic [SS_W-1:0] err_cmd,
    input logic            out_en,
    input logic [SS_W-1:0] cmd_out,
    input logic            fault_st,
    input logic [2:0]      state_o,
    input logic [SS_W-1:0] ss_lvl
);
    // R1
    reset_lockout_chk: assert property (@(posedge clk)
        rst |=> (state_o == 3'd0) && !fault_st);

    // R2
    supply_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (state_o == 3'd0) && !fault_st && (ss_lvl == '0));

    // R3
    ramp_rises_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1) && supply_ok && !oc_flag |=> ss_lvl >= $past(ss_lvl));

    // R4
    cmd_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_out <= err_cmd) && (cmd_out <= ss_lvl));

    // R6
    oc_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        oc_flag |-> !out_en);

    // R7
    drain_falls_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4) && supply_ok |=> ss_lvl <= $past(ss_lvl));

    // R8
    ss_fault_charge_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1) && supply_ok && oc_flag |=> (state_o == 3'd3));

    // R9
    hold_in_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4) && supply_ok && oc_flag |=> (state_o == 3'd4));

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fault_st |-> !out_en && (cmd_out == '0));

endmodule

bind hiccup_seq hiccup_seq_chk #(.SS_W(SS_W)) u_chk (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .oc_flag(oc_flag),
    .err_cmd(err_cmd), .out_en(out_en), .cmd_out(cmd_out),
    .fault_st(fault_st), .state_o(state_o), .ss_lvl(ss_q)
);

// File: tb/test_hiccup_seq.sv
module test_hiccup_seq;
    localparam int W    = 8;
    localparam int CHG  = 2;
    localparam int DIS  = 6;
    localparam int FULL = 61;
    localparam int RSTL = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         supply_ok = 1'b0;
    logic         oc_flag = 1'b0;
    logic [W-1:0] err_cmd = '0;
    logic         out_en;
    logic [W-1:0] cmd_out;
    logic         fault_st;
    logic [2:0]   state_o;

    always #2 clk = ~clk;   // 250 MHz

    hiccup_seq #(
        .SS_W(W), .CHG_STEP(CHG), .DIS_STEP(DIS), .FULL_LVL(FULL), .RESTART_LVL(RSTL)
    ) i_hiccup_seq (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .oc_flag(oc_flag),
        .err_cmd(err_cmd), .out_en(out_en), .cmd_out(cmd_out),
        .fault_st(fault_st), .state_o(state_o)
    );

    typedef struct {
        int    st;
        bit    en;
        int    cmd;
        bit    flt;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // behavioural expectation, built from the requirement text
    int m_st = 0;
    int m_ss = 0;

    task automatic cyc(input bit s, input bit o, input int e, input string tag);
        exp_t x;
        bit   act;
        @(negedge clk);
        supply_ok = s;
        oc_flag   = o;
        err_cmd   = W'(e);
        act   = (m_st == 1) || (m_st == 2);
        x.st  = m_st;
        x.en  = act && !o;
        x.cmd = act ? ((e < m_ss) ? e : m_ss) : 0;
        x.flt = (m_st == 3) || (m_st == 4);
        x.tag = tag;
        q.push_back(x);
        if (!s) begin
            m_st = 0; m_ss = 0;
        end else begin
            case (m_st)
                0: begin m_st = 1; m_ss = 0; end
                1: begin
                    if (o) m_st = 3; else if (m_ss >= FULL) m_st = 2;
                    m_ss = (m_ss + CHG > FULL) ? FULL : m_ss + CHG;
                end
                2: begin
                    if (o) m_st = 4;
                    m_ss = (m_ss + CHG > FULL) ? FULL : m_ss + CHG;
                end
                3: begin
                    if (m_ss >= FULL) m_st = 4;
                    m_ss = (m_ss + CHG > FULL) ? FULL : m_ss + CHG;
                end
                default: begin
                    if (m_ss < RSTL && !o) m_st = 1;
                    m_ss = (m_ss < DIS) ? 0 : m_ss - DIS;
                end
            endcase
        end
    endtask

    task automatic run_n(input int n, input bit s, input bit o, input int e, input string tag);
        for (int i = 0; i < n; i++) cyc(s, o, e, tag);
    endtask

    // monitor: compare mid-cycle, away from the active edge
    always @(negedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            n_chk++;
            if (state_o != 3'(x.st) || out_en != x.en || cmd_out != W'(x.cmd) || fault_st != x.flt) begin
                n_fail++;
                $display("FAIL %s: st=%0d en=%0d cmd=%0d flt=%0d expected st=%0d en=%0d cmd=%0d flt=%0d",
                         x.tag, state_o, out_en, cmd_out, fault_st, x.st, x.en, x.cmd, x.flt);
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // R1: lockout after reset with supply low
        run_n(3, 0, 0, 255, "R1");
        // R3 / R4: ramp, clamped command follows the level, then the error command
        run_n(10, 1, 0, 255, "R4");
        run_n(5, 1, 0, 3, "R4");
        run_n(20, 1, 0, 255, "R3");
        run_n(3, 1, 0, 255, "R5");
        run_n(2, 1, 0, 20, "R4");
        // R6 / R7 / R9: fault from run, drain held by persistent flag
        cyc(1, 1, 20, "R6");
        run_n(2, 1, 0, 20, "R10");
        run_n(12, 1, 1, 20, "R9");
        run_n(4, 1, 0, 20, "R7");
        // R8: fault during soft start charges to full before drain
        run_n(3, 1, 0, 255, "R3");
        cyc(1, 1, 255, "R6");
        run_n(45, 1, 0, 255, "R8");
        // R2: supply lost in fault, new ramp from zero
        run_n(4, 1, 0, 255, "R3");
        cyc(1, 1, 255, "R6");
        run_n(3, 1, 0, 255, "R10");
        run_n(2, 0, 0, 255, "R2");
        run_n(6, 1, 0, 255, "R2");
        // R2: supply lost in run
        run_n(35, 1, 0, 255, "R5");
        run_n(2, 0, 0, 255, "R2");
        run_n(3, 1, 0, 255, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule